// File: doc/BRIEF.md
# Privileged Preemption Countdown Timer

This block bounds how long a user program may hold the processor. Before handing control to user code, the kernel writes an interval into the timer. The timer then counts that interval down, one step per enabled tick. When the interval runs out, the timer stops and raises an interrupt request, which hands control back to the operating system. The request stays high until the interrupt handler acknowledges it.

Only kernel-mode code may write the interval. A write attempted while the processor is in user mode changes nothing in the timer and produces a one-cycle violation flag, which the surrounding logic can turn into a trap. The current count, the running flag and the interrupt request can be read at all times, in either mode. The counter never wraps: once it reaches zero it holds there until the next accepted write.

Top module: `preempt_timer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state clears count, running, timer_irq and load_violation to 0.
- R2: A write with load_stb=1 and user_mode=0 (kernel) sets count to load_val and running to 1 one cycle later. This holds whatever the values of tick_en and count.
- R3: A write with load_stb=1 and user_mode=1 (user) does not load count or running. load_violation is 1 for exactly the following cycle.
- R4: If no write is accepted, running=1, tick_en=1 and count>1, then count decreases by exactly one in the next cycle.
- R5: While tick_en=0 and no write is accepted, count and running hold their values.
- R6: An enabled tick that finds count=1 while running leaves count=0 and running=0, and sets timer_irq, all in the next cycle.
- R7: After a kernel write of 0, count stays 0 and running=1 until the next enabled tick. That tick clears running and sets timer_irq.
- R8: Once set, timer_irq stays 1 until an acknowledge arrives (irq_ack=1).
- R9: irq_ack=1 clears timer_irq in the next cycle, unless an expiry happens in the same cycle.
- R10: If an expiry and irq_ack fall in the same cycle, timer_irq is 1 afterwards.
- R11: While stopped (running=0) with no accepted write, enabled ticks leave count unchanged (no wrap below zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Clock enable; one count step per cycle in which it is high |
| load_stb | input | 1 | Request to write the interval |
| load_val | input | CNT_W | Interval to write |
| user_mode | input | 1 | Current privilege: 0 kernel, 1 user |
| irq_ack | input | 1 | Acknowledge of the timer interrupt |
| count | output | CNT_W | Current remaining count, readable in any mode |
| running | output | 1 | Timer is counting |
| timer_irq | output | 1 | Expiry interrupt request, held until acknowledged |
| load_violation | output | 1 | One-cycle flag for a write attempted in user mode |

## Verification
Every output is registered once, so the result of the inputs present at one rising edge appears on the ports right after that edge. None of count, running, timer_irq or load_violation takes longer than one cycle. The bench changes inputs on the falling edge, waits for the next rising edge, and samples one nanosecond later, before the following falling edge. As a result, each table row checks exactly the state that one edge produced. An expiry needs as many enabled ticks as the interval written, or a single tick after a write of zero. The rows count these ticks out one by one.

// File: rtl/timer_pkg.sv
// Shared types of the preemption timer.
// Assumes: privilege arrives as a single bit, 0 = kernel, 1 = user.
package timer_pkg;
    typedef enum logic {
        MODE_KERNEL = 1'b0,
        MODE_USER   = 1'b1
    } priv_mode_e;
endpackage

// File: rtl/priv_gate.sv
// Privilege gate: passes a write request on only in kernel mode, and
// registers a one-cycle violation flag for a request made in user mode.
// Assumes: load_stb and mode are synchronous to clk.
module priv_gate
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_stb,
    input  priv_mode_e mode,
    output logic       ld_ok,
    output logic       viol
);
    // Decode: accept only kernel-mode writes.
    always_comb begin
        ld_ok = load_stb && (mode == MODE_KERNEL);
    end

    // Flag a rejected write for exactly the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= load_stb && (mode == MODE_USER);
    end

    // R3: a user-mode write raises the flag on the next cycle.
    a_r3_flag_user_write: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && mode == MODE_USER) |=> viol);
    // R3: a kernel write or an idle cycle raises no flag.
    a_r3_no_flag_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb && mode == MODE_USER) |=> !viol);
endmodule

// File: rtl/down_counter.sv
// Down counter with a stop at zero: an accepted write loads it and starts it,
// and each enabled tick takes one step. A tick that finds 1 or 0 ends the
// run and emits a one-cycle expiry strobe (combinational).
// Assumes: ld_ok has priority over tick in the same cycle.
module down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_ok,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Expiry: the last enabled tick of a run.
    always_comb begin
        expire = !ld_ok && run && tick && (cnt <= ONE);
    end

    // Count state: load, step, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (ld_ok) begin
            cnt <= ld_val;
            run <= 1'b1;
        end else if (expire) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (run && tick) begin
            cnt <= cnt - ONE;
        end
    end

    // R2: an accepted write loads the value and starts the run.
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |=> (cnt == $past(ld_val)) && run);
    // R4: one step per enabled tick while above one.
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ok && run && tick && cnt > ONE) |=> (cnt == $past(cnt) - ONE) && run);
    // R5: no tick, no accepted write: nothing moves.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ok && !tick) |=> $stable(cnt) && $stable(run));
    // R6: expiry leaves the counter stopped at zero.
    a_r6_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == '0) && !run);
    // R11: a stopped counter does not wrap.
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ok && !run) |=> $stable(cnt) && !run);
endmodule

// File: rtl/irq_latch.sv
// Interrupt request latch: set by expiry, cleared by acknowledge.
// Assumes: set has priority over ack in the same cycle.
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    // Hold the request until acknowledged; a new expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (ack) irq <= 1'b0;
    end

    // R8: the request is sticky without an acknowledge.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    // R9: an acknowledge clears it when no expiry coincides.
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !irq);
    // R10: an expiry raises it even against an acknowledge.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
endmodule

// File: rtl/preempt_timer.sv
// Preemption timer top: the kernel writes an interval, the timer counts it
// down on enabled ticks and requests an interrupt at zero. User-mode writes
// are rejected and flagged. All outputs are registered.
// Assumes: all inputs synchronous to clk; user_mode 0 = kernel, 1 = user.
module preempt_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             user_mode,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             timer_irq,
    output logic             load_violation
);
    logic       ld_ok;
    logic       expire;
    priv_mode_e mode;

    // Map the privilege pin onto the mode type.
    always_comb begin
        mode = priv_mode_e'(user_mode);
    end

    priv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .mode     (mode),
        .ld_ok    (ld_ok),
        .viol     (load_violation)
    );

    down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_ok  (ld_ok),
        .ld_val (load_val),
        .tick   (tick_en),
        .cnt    (count),
        .run    (running),
        .expire (expire)
    );

    irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .ack   (irq_ack),
        .irq   (timer_irq)
    );

    // R3: a user-mode write without a tick leaves the count untouched.
    a_r3_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && user_mode && !tick_en) |=> $stable(count) && $stable(running));
    // R7: a running zero count expires on the next enabled tick.
    a_r7_zero_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == '0 && tick_en && !(load_stb && !user_mode)) |=> timer_irq && !running);
endmodule

// File: tb/preempt_timer_bench.sv
// Table-driven bench for preempt_timer, then directed reset checks.
module preempt_timer_bench;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic        ld;
        logic        usr;
        logic [15:0] val;
        logic        tk;
        logic        ack;
        logic [15:0] ec;
        logic        er;
        logic        ei;
        logic        ev;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        //  ld    usr   val       tk    ack   count     run   irq   viol  req
        '{1'b1,1'b0,16'd3,    1'b0,1'b0,16'd3,    1'b1,1'b0,1'b0,4'd2 },  // R2 kernel write
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'd2,    1'b1,1'b0,1'b0,4'd4 },  // R4 step
        '{1'b0,1'b0,16'd0,    1'b0,1'b0,16'd2,    1'b1,1'b0,1'b0,4'd5 },  // R5 hold
        '{1'b1,1'b1,16'd9,    1'b0,1'b0,16'd2,    1'b1,1'b0,1'b1,4'd3 },  // R3 user write ignored
        '{1'b1,1'b1,16'd9,    1'b1,1'b0,16'd1,    1'b1,1'b0,1'b1,4'd3 },  // R3 rejected, tick goes on
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'd0,    1'b0,1'b1,1'b0,4'd6 },  // R6 expiry
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'd0,    1'b0,1'b1,1'b0,4'd11},  // R11 no wrap, R8 sticky
        '{1'b0,1'b0,16'd0,    1'b0,1'b1,16'd0,    1'b0,1'b0,1'b0,4'd9 },  // R9 ack clears
        '{1'b1,1'b0,16'd0,    1'b0,1'b0,16'd0,    1'b1,1'b0,1'b0,4'd7 },  // R7 write zero
        '{1'b0,1'b0,16'd0,    1'b0,1'b0,16'd0,    1'b1,1'b0,1'b0,4'd7 },  // R7 waits for tick
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'd0,    1'b0,1'b1,1'b0,4'd7 },  // R7 fires
        '{1'b1,1'b0,16'd2,    1'b0,1'b1,16'd2,    1'b1,1'b0,1'b0,4'd9 },  // R9 ack with write
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'd1,    1'b1,1'b0,1'b0,4'd4 },  // R4 step
        '{1'b0,1'b0,16'd0,    1'b1,1'b1,16'd0,    1'b0,1'b1,1'b0,4'd10},  // R10 expiry beats ack
        '{1'b1,1'b0,16'hFFFF, 1'b1,1'b0,16'hFFFF, 1'b1,1'b1,1'b0,4'd2 },  // R2 write beats tick, R8
        '{1'b0,1'b0,16'd0,    1'b1,1'b0,16'hFFFE, 1'b1,1'b1,1'b0,4'd4 },  // R4 from max
        '{1'b0,1'b0,16'd0,    1'b0,1'b1,16'hFFFE, 1'b1,1'b0,1'b0,4'd9 }   // R9 ack while running
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             load_stb = 1'b0;
    logic [CNT_W-1:0] load_val = '0;
    logic             user_mode = 1'b0;
    logic             irq_ack = 1'b0;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             timer_irq;
    logic             load_violation;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    preempt_timer #(.CNT_W(CNT_W)) u_preempt_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .load_stb       (load_stb),
        .load_val       (load_val),
        .user_mode      (user_mode),
        .irq_ack        (irq_ack),
        .count          (count),
        .running        (running),
        .timer_irq      (timer_irq),
        .load_violation (load_violation)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input int ec, input int er, input int ei, input int ev);
        check(req, "count", int'(count), ec);
        check(req, "running", int'(running), er);
        check(req, "timer_irq", int'(timer_irq), ei);
        check(req, "load_violation", int'(load_violation), ev);
    endtask

    task automatic idle();
        load_stb = 1'b0; user_mode = 1'b0; tick_en = 1'b0; irq_ack = 1'b0; load_val = '0;
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1 check_all(1, 0, 0, 0, 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_stb = VEC[i].ld; user_mode = VEC[i].usr; load_val = VEC[i].val;
            tick_en = VEC[i].tk; irq_ack = VEC[i].ack;
            @(posedge clk);
            #1 check_all(int'(VEC[i].req), int'(VEC[i].ec), int'(VEC[i].er),
                         int'(VEC[i].ei), int'(VEC[i].ev));
        end

        // R1: reset in the middle of a run with a pending request
        @(negedge clk) idle(); load_stb = 1'b1; load_val = 16'd1;
        @(negedge clk) idle(); tick_en = 1'b1;
        @(negedge clk) idle(); load_stb = 1'b1; load_val = 16'd5;
        @(negedge clk) idle(); load_stb = 1'b1; user_mode = 1'b1; rst_n = 1'b0;
        @(posedge clk);
        #1 check_all(1, 0, 0, 0, 0);
        @(negedge clk) idle(); rst_n = 1'b1;

        // R5: a long stretch without ticks keeps the count
        @(negedge clk) idle(); load_stb = 1'b1; load_val = 16'd4;
        @(negedge clk) idle();
        repeat (5) @(posedge clk);
        #1 check_all(5, 4, 1, 0, 0);

        // R3: the violation flag lasts one cycle only
        @(negedge clk) idle(); load_stb = 1'b1; user_mode = 1'b1; load_val = 16'd7;
        @(negedge clk) idle();
        @(posedge clk);
        #1 check_all(3, 4, 1, 0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R0 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule